// File: doc/BRIEF.md
# Service-Restart Watchdog with Selectable Timeout

This block is a computer-operating-properly watchdog. Once enabled it counts internal clock cycles. If software does not service it before the selected period runs out, it raises a reset request that lasts exactly one clock. Software services it by writing to a single fixed bus address. The data of that write is irrelevant, so only the address and the write strobe reach the block. A read of the same address returns the low byte of the reset vector, which the block takes in as an input. The watchdog never raises an interrupt.

The period is a power of two minus a small guard term. A rate input chooses between a short exponent and a long exponent. With the default parameters the short period is 8176 cycles and the long period is 262128 cycles.

The block can be held off in three ways:
- a configuration disable bit;
- a test-voltage indication, which holds it off only while that indication is present;
- a blank-vector monitor entry, which holds it off until the next power-on reset. An ordinary reset does not release this one.

Top module: `cop_watchdog`

## Requirements
- R1: With `cfg_fast` = 1, the reset request pulse appears 2^SHORT_EXP − 2^GUARD_EXP cycles after the counter restarts (after reset release or after a previous pulse).
- R2: With `cfg_fast` = 0, the period is 2^LONG_EXP − 2^GUARD_EXP cycles.
- R3: `wdog_rst` is high for exactly one clock. The count then restarts from zero, so the next pulse follows one full period later.
- R4: A write strobe at address SVC_ADDR clears the count in that cycle, including in the cycle that would otherwise expire. The next pulse follows a full period after the write.
- R5: A write to any address other than SVC_ADDR has no effect on the count.
- R6: A read at SVC_ADDR drives `vec_lo` on `bus_rdata`. Any other read, and any cycle without a read, drives zero.
- R7: While `cfg_off` = 1 there is no reset request and the count is held at zero. After release, a full period must elapse before a pulse.
- R8: While `mon_hv` = 1 the watchdog is held off exactly as in R7, and only for as long as the input stays high.
- R9: A one-cycle `mon_blank_entry` latches a disable. That disable survives `rst_n` and is cleared only by `por_n`.
- R10: If the rate changes to short while the count is already at or beyond the short terminal, the pulse comes on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low; clears the blank-vector disable |
| cfg_fast | input | 1 | Rate select: 1 selects the short period, 0 the long period |
| cfg_off | input | 1 | Configuration disable |
| mon_hv | input | 1 | Test voltage present on the monitor-entry pin |
| mon_blank_entry | input | 1 | Pulse: monitor mode entered through blank vectors |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| vec_lo | input | 8 | Low byte of the reset vector |
| bus_rdata | output | 8 | Read data |
| wdog_rst | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach from the ports is a service write that lands in the very cycle the count would otherwise expire. Producing it requires knowing the exact count at every cycle.

The bench gets there by sweeping every service offset from zero up to one cycle short of the terminal. Each sweep starts from a freshly observed pulse, and a pulse is the only moment when the count is known to be zero. The bench uses a small configuration (exponents 8 and 12), so that sweep is exhaustive and the long period stays short.

The blank-vector disable must be shown to survive an ordinary reset. The bench therefore applies `rst_n` alone while the disable is latched, and applies `por_n` only afterwards.

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
  parameter int SHORT_EXP = 13,
  parameter int LONG_EXP = 18,
  parameter int GUARD_EXP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              cfg_fast,
  input  logic              cfg_off,
  input  logic              mon_hv,
  input  logic              mon_blank_entry,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        vec_lo,
  output logic [7:0]        bus_rdata,
  output logic              wdog_rst
);
  localparam int CW = LONG_EXP + 1;
  localparam logic [CW-1:0] TERM_S = CW'((1 << SHORT_EXP) - (1 << GUARD_EXP));
  localparam logic [CW-1:0] TERM_L = CW'((1 << LONG_EXP) - (1 << GUARD_EXP));

  logic [CW-1:0] cnt;
  logic          blank_lock;

  wire           hit    = (bus_addr == SVC_ADDR);
  wire           active = !cfg_off && !mon_hv && !blank_lock;
  wire           svc    = bus_wr && hit;
  wire [CW-1:0]  last   = cfg_fast ? TERM_S - 1'b1 : TERM_L - 1'b1;
  wire           expire = active && !svc && (cnt >= last);

  assign bus_rdata = (bus_rd && hit) ? vec_lo : 8'h00;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)               blank_lock <= 1'b0;
    else if (mon_blank_entry) blank_lock <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= '0;
      wdog_rst <= 1'b0;
    end else begin
      wdog_rst <= expire;
      if (!active || svc || expire) cnt <= '0;
      else                          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
  parameter int CW = 19,
  parameter logic [CW-1:0] TERM_S = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              cfg_off,
  input logic              mon_hv,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wdog_rst,
  input logic [CW-1:0]     cnt,
  input logic              blank_lock
);
  p_term_reached_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> ($past(cnt) >= TERM_S - 1'b1));
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);
  p_service_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SVC_ADDR) |=> !wdog_rst);
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_off |=> !wdog_rst);
  p_hv_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mon_hv |=> !wdog_rst);
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    blank_lock |=> (blank_lock && !wdog_rst));
endmodule

bind cop_watchdog cop_watchdog_chk #(
  .ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR), .CW(CW), .TERM_S(TERM_S)
) u_chk (.*);

// File: tb/sim_cop_watchdog.sv
module sim_cop_watchdog;
  localparam int SE = 8, LE = 12, GE = 4;
  localparam int TS = (1 << SE) - (1 << GE);
  localparam int TL = (1 << LE) - (1 << GE);
  localparam logic [15:0] SVC = 16'hFFFF;

  logic clk = 0, rst_n = 0, por_n = 0;
  logic cfg_fast = 1, cfg_off = 0, mon_hv = 0, mon_blank_entry = 0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] vec_lo = 8'hA5, bus_rdata;
  logic wdog_rst;
  int checks = 0, errs = 0, n;
  bit done = 0;

  always #2 clk = ~clk;

  cop_watchdog #(.ADDR_W(16), .SVC_ADDR(SVC), .SHORT_EXP(SE), .LONG_EXP(LE), .GUARD_EXP(GE)) u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(input int limit, output int r);
    r = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (wdog_rst) begin r = i; return; end
    end
  endtask

  task automatic svc_write(input logic [15:0] a);
    bus_addr = a; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_addr = '0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(wdog_rst == 0 && bus_rdata == 0, "reset R3", wdog_rst, 0);
    por_n = 1; rst_n = 1;
    wait_pulse(TS + 10, n); check(n == TS, "R1 first period", n, TS);
    @(negedge clk); check(wdog_rst == 0, "R3 single cycle", wdog_rst, 0);
    wait_pulse(TS + 10, n); check(n == TS - 1, "R3 restart", n, TS - 1);
    for (int k = 0; k < TS; k++) begin
      if (k > 0) begin
        wait_pulse(k, n); check(n == 0, "R4 pre-service quiet", n, 0);
      end
      svc_write(SVC);
      check(wdog_rst == 0, "R4 service edge", wdog_rst, 0);
      wait_pulse(TS + 5, n); check(n == TS, "R4 service offset", n, TS);
    end
    wait_pulse(100, n); check(n == 0, "R5 quiet", n, 0);
    svc_write(SVC - 16'd1);
    wait_pulse(TS + 5, n); check(n == TS - 101, "R5 other address", n, TS - 101);
    bus_rd = 1; bus_addr = SVC; #1;
    check(bus_rdata == 8'hA5, "R6 read vector", bus_rdata, 8'hA5);
    vec_lo = 8'h3C; #1;
    check(bus_rdata == 8'h3C, "R6 read vector 2", bus_rdata, 8'h3C);
    bus_addr = 16'h1234; #1;
    check(bus_rdata == 0, "R6 other read", bus_rdata, 0);
    bus_rd = 0; bus_addr = SVC; #1;
    check(bus_rdata == 0, "R6 no read", bus_rdata, 0);
    bus_addr = '0;
    @(negedge clk); cfg_fast = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    wait_pulse(TL + 10, n); check(n == TL, "R2 long period", n, TL);
    wait_pulse(TL + 10, n); check(n == TL, "R2 long repeat", n, TL);
    wait_pulse(1000, n); check(n == 0, "R10 quiet", n, 0);
    cfg_fast = 1;
    wait_pulse(5, n); check(n == 1, "R10 rate switch", n, 1);
    cfg_off = 1;
    wait_pulse(2 * TL, n); check(n == 0, "R7 disabled", n, 0);
    cfg_off = 0;
    wait_pulse(TS + 5, n); check(n == TS, "R7 after release", n, TS);
    wait_pulse(100, n);
    mon_hv = 1;
    wait_pulse(2 * TS, n); check(n == 0, "R8 hv held", n, 0);
    mon_hv = 0;
    wait_pulse(TS + 5, n); check(n == TS, "R8 after release", n, TS);
    mon_blank_entry = 1; @(negedge clk); mon_blank_entry = 0;
    wait_pulse(2 * TS, n); check(n == 0, "R9 locked", n, 0);
    rst_n = 0; @(negedge clk); rst_n = 1;
    wait_pulse(2 * TS, n); check(n == 0, "R9 survives rst_n", n, 0);
    por_n = 0; rst_n = 0; @(negedge clk); por_n = 1; rst_n = 1;
    wait_pulse(TS + 5, n); check(n == TS, "R9 cleared by por_n", n, TS);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      summary();
      $finish;
    end
  end
endmodule